// File: doc/BRIEF.md
# Quasi-Bidirectional Port Bit Array

This block is the register side of a general-purpose microcontroller port of up to eight pins. The CPU loads a port latch through a write strobe and reads back over one data bus, using either of two paths. The latch path returns the stored latch bits, and read-modify-write sequences must use it. The pin path returns the pad levels after they pass through a two-flop synchronizer. The synchronized levels also go out continuously to peripherals that take alternate-function inputs.

Each pin has only a pull-down driver and an internal pull-up. A latch bit of 0 switches the pull-down on and holds the pin low. A latch bit of 1 hands control of the pin to the alternate-function output of the peripheral. If that output is 1, or the pin has no alternate function, the pin is released high. An outside source can still pull a released pin low, and this is how a pin acts as an input. Each bit is independent of the others.

Top module: `qbp_port_array`

## Requirements
- R1: After reset every latch bit is 1, every `pull_dn_o` bit is 0, and `pin_in_o` reads all ones.
- R2: When `wr_latch_i` is high at a rising clock edge, the latch takes `wr_data_i` bit for bit at that edge. Otherwise the latch holds its value.
- R3: When a latch bit is 0, the matching `pull_dn_o` bit is 1, whatever the alternate output.
- R4: On a pin with an alternate function, when the latch bit is 1, `pull_dn_o` is the inverse of the matching `alt_out_i` bit.
- R5: A pin whose bit in parameter `ALT_MASK` is 0 (the default `8'hF0` leaves pins 0 to 3 without an alternate function) ignores `alt_out_i`. Its `pull_dn_o` is the inverse of its latch bit.
- R6: `pin_in_o` and the read-pin path show a change on `pin_i` after the second rising edge that follows the change, and not after the first.
- R7: When `rd_latch_i` is high, `rd_data_o` returns the latch contents, even if `rd_pin_i` is also high.
- R8: When only `rd_pin_i` is high, `rd_data_o` returns the synchronized pin levels.
- R9: When neither read strobe is high, `rd_data_o` is all zeros.
- R10: If an outside source pulls a released pin low, the latch read still returns 1 for that bit while the pin read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_latch_i | input | 1 | Write strobe for the port latch |
| wr_data_i | input | NUM_PINS | Internal bus write data |
| rd_latch_i | input | 1 | Read-latch strobe |
| rd_pin_i | input | 1 | Read-pin strobe |
| alt_out_i | input | NUM_PINS | Alternate-function output levels from peripherals |
| pin_i | input | NUM_PINS | Pad levels as seen on the pins |
| rd_data_o | output | NUM_PINS | Read data bus |
| pull_dn_o | output | NUM_PINS | Pull-down enable for each pin |
| pin_in_o | output | NUM_PINS | Synchronized pin levels for alternate-function inputs |

## Verification
The bench drives the pins through a model of a pull-up plus an outside pull-down. This lets it test the read-modify-write case. A design that fed the pin path into the latch read would return 0 for a bit that is pulled low from outside. The bench samples the synchronizer after one edge and after two, so a single-flop or three-flop sampler gives the wrong value at one of those points. It also drives alternate outputs to 0 on pins with no alternate function, which catches a design that gates every pin. It raises both read strobes together to check the priority, and raises neither to check that the bus reads zero.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
  typedef enum logic [1:0] {RSEL_NONE, RSEL_LATCH, RSEL_PIN} rsel_e;

  function automatic rsel_e pick_src(input logic rd_latch, input logic rd_pin);
    if (rd_latch)    return RSEL_LATCH;
    else if (rd_pin) return RSEL_PIN;
    else             return RSEL_NONE;
  endfunction
endpackage

// File: rtl/qbp_latch.sv
module qbp_latch #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [NUM_PINS-1:0] d_i,
  output logic [NUM_PINS-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '1;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/qbp_sync.sv
module qbp_sync #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] async_i,
  output logic [NUM_PINS-1:0] sync_o
);
  logic [NUM_PINS-1:0] stage1_q;
  // reset to ones: pins idle high through pull-ups
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '1;
      sync_o   <= '1;
    end else begin
      stage1_q <= async_i;
      sync_o   <= stage1_q;
    end
  end
endmodule

// File: rtl/qbp_drive.sv
module qbp_drive #(
  parameter int                     NUM_PINS = 8,
  parameter logic [NUM_PINS-1:0]    ALT_MASK = '0
) (
  input  logic [NUM_PINS-1:0] latch_i,
  input  logic [NUM_PINS-1:0] alt_out_i,
  output logic [NUM_PINS-1:0] pull_dn_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic alt_eff;
    // pins without an alternate function see a constant 1
    assign alt_eff      = alt_out_i[i] | ~ALT_MASK[i];
    assign pull_dn_o[i] = ~(latch_i[i] & alt_eff);
  end
endmodule

// File: rtl/qbp_port_array.sv
module qbp_port_array
  import qbp_pkg::*;
#(
  parameter int                  NUM_PINS = 8,
  parameter logic [NUM_PINS-1:0] ALT_MASK = 8'hF0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_latch_i,
  input  logic [NUM_PINS-1:0] wr_data_i,
  input  logic                rd_latch_i,
  input  logic                rd_pin_i,
  input  logic [NUM_PINS-1:0] alt_out_i,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] rd_data_o,
  output logic [NUM_PINS-1:0] pull_dn_o,
  output logic [NUM_PINS-1:0] pin_in_o
);
  logic [NUM_PINS-1:0] latch_q;
  logic [NUM_PINS-1:0] pin_sync;
  rsel_e               rsel;

  qbp_latch #(.NUM_PINS(NUM_PINS)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (wr_latch_i),
    .d_i   (wr_data_i),
    .q_o   (latch_q)
  );

  qbp_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pin_i),
    .sync_o (pin_sync)
  );

  qbp_drive #(.NUM_PINS(NUM_PINS), .ALT_MASK(ALT_MASK)) u_drive (
    .latch_i  (latch_q),
    .alt_out_i(alt_out_i),
    .pull_dn_o(pull_dn_o)
  );

  assign rsel     = pick_src(rd_latch_i, rd_pin_i);
  assign pin_in_o = pin_sync;

  always_comb begin
    unique case (rsel)
      RSEL_LATCH: rd_data_o = latch_q;
      RSEL_PIN:   rd_data_o = pin_sync;
      default:    rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/qbp_port_checker.sv
module qbp_port_checker #(
  parameter int                  NUM_PINS = 8,
  parameter logic [NUM_PINS-1:0] ALT_MASK = 8'hF0
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_latch_i,
  input logic [NUM_PINS-1:0] wr_data_i,
  input logic                rd_latch_i,
  input logic                rd_pin_i,
  input logic [NUM_PINS-1:0] alt_out_i,
  input logic [NUM_PINS-1:0] pin_i,
  input logic [NUM_PINS-1:0] rd_data_o,
  input logic [NUM_PINS-1:0] pull_dn_o,
  input logic [NUM_PINS-1:0] pin_in_o,
  input logic [NUM_PINS-1:0] latch_q
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         age_q <= '0;
    else if (age_q != 2) age_q <= age_q + 2'd1;
  end

  assert_write_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_latch_i |=> latch_q == $past(wr_data_i));
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_latch_i |=> $stable(latch_q));
  assert_low_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~latch_q & ~pull_dn_o) == '0);
  assert_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q & (alt_out_i | ~ALT_MASK) & pull_dn_o) == '0);
  assert_sync_depth_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q == 2 |-> pin_in_o == $past(pin_i, 2));
  assert_rd_prio_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_latch_i |-> rd_data_o == latch_q);
  assert_rd_pin_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pin_i && !rd_latch_i) |-> rd_data_o == pin_in_o);
  assert_rd_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_pin_i && !rd_latch_i) |-> rd_data_o == '0);
endmodule

bind qbp_port_array qbp_port_checker #(.NUM_PINS(NUM_PINS), .ALT_MASK(ALT_MASK)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_latch_i(wr_latch_i),
  .wr_data_i (wr_data_i),
  .rd_latch_i(rd_latch_i),
  .rd_pin_i  (rd_pin_i),
  .alt_out_i (alt_out_i),
  .pin_i     (pin_i),
  .rd_data_o (rd_data_o),
  .pull_dn_o (pull_dn_o),
  .pin_in_o  (pin_in_o),
  .latch_q   (latch_q)
);

// File: tb/sim_qbp_port_array.sv
module sim_qbp_port_array;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         wr_latch = 0;
  logic [N-1:0] wr_data = '0;
  logic         rd_latch = 0;
  logic         rd_pin = 0;
  logic [N-1:0] alt_out = '1;
  logic [N-1:0] ext_low = '0;
  logic [N-1:0] pin_w;
  logic [N-1:0] rd_data, pull_dn, pin_in;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // pad model: pull-up, released unless our pull-down or an outside source pulls low
  assign pin_w = ~pull_dn & ~ext_low;

  qbp_port_array #(.NUM_PINS(N), .ALT_MASK(8'hF0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_latch_i(wr_latch), .wr_data_i(wr_data),
    .rd_latch_i(rd_latch), .rd_pin_i(rd_pin), .alt_out_i(alt_out), .pin_i(pin_w),
    .rd_data_o(rd_data), .pull_dn_o(pull_dn), .pin_in_o(pin_in)
  );

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  task automatic write_latch(input logic [N-1:0] v);
    @(negedge clk);
    wr_data = v; wr_latch = 1;
    edges(1);
    wr_latch = 0;
  endtask

  task automatic read_latch(output logic [N-1:0] v);
    rd_latch = 1; rd_pin = 0; #1; v = rd_data; rd_latch = 0;
  endtask

  task automatic read_pin(output logic [N-1:0] v);
    rd_latch = 0; rd_pin = 1; #1; v = rd_data; rd_pin = 0;
  endtask

  task automatic t_reset;
    logic [N-1:0] v;
    read_latch(v);
    check("R1 latch", v, 8'hFF);
    check("R1 pull_dn", pull_dn, 8'h00);
    check("R1 pin_in", pin_in, 8'hFF);
  endtask

  task automatic t_write;
    logic [N-1:0] v;
    write_latch(8'hA5);
    read_latch(v);
    check("R2 load", v, 8'hA5);
    @(negedge clk); wr_data = 8'h00;
    edges(2);
    read_latch(v);
    check("R2 hold", v, 8'hA5);
    check("R3 pull_dn", pull_dn, 8'h5A);
  endtask

  task automatic t_low_any_alt;
    write_latch(8'h00);
    alt_out = 8'h00; #1;
    check("R3 alt0", pull_dn, 8'hFF);
    alt_out = 8'hFF; #1;
    check("R3 alt1", pull_dn, 8'hFF);
  endtask

  task automatic t_alt;
    write_latch(8'hFF);
    alt_out = 8'h5F; #1;
    check("R4 gate", pull_dn, 8'hA0);
    alt_out = 8'hFF; #1;
    check("R4 release", pull_dn, 8'h00);
  endtask

  task automatic t_no_alt;
    alt_out = 8'h00; #1;
    check("R5 ignored", pull_dn, 8'hF0);
    write_latch(8'hF6);
    check("R5 latch low", pull_dn, 8'hF9);
    alt_out = 8'hFF;
    write_latch(8'hFF);
  endtask

  task automatic t_sync;
    logic [N-1:0] v;
    edges(3);
    @(negedge clk); ext_low = 8'h3C;
    edges(1);
    read_pin(v);
    check("R6 one edge", v, 8'hFF);
    check("R6 pin_in one edge", pin_in, 8'hFF);
    edges(1);
    read_pin(v);
    check("R6 two edges", v, 8'hC3);
    check("R8 pin path", v, pin_in);
    ext_low = 8'h00;
    edges(3);
  endtask

  task automatic t_prio;
    write_latch(8'h0F);
    edges(3);
    rd_latch = 1; rd_pin = 1; #1;
    check("R7 both", rd_data, 8'h0F);
    rd_latch = 0; #1;
    check("R8 pin only", rd_data, 8'h0F);
    rd_pin = 0; #1;
    check("R9 idle", rd_data, 8'h00);
    write_latch(8'hFF);
  endtask

  task automatic t_rmw;
    logic [N-1:0] v;
    @(negedge clk); ext_low = 8'h81;
    edges(3);
    read_latch(v);
    check("R10 latch", v, 8'hFF);
    read_pin(v);
    check("R10 pin", v, 8'h7E);
    ext_low = 8'h00;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    rst_n = 1;
    edges(1);
    t_reset();
    t_write();
    t_low_any_alt();
    t_alt();
    t_no_alt();
    t_sync();
    t_prio();
    t_rmw();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule